// File: doc/BRIEF.md
# Segmented Program-Flow Unit

This block is the sequencing core of a small accumulator machine. It owns the program counter, the segment that instructions are currently fetched from, and the code-segment register that software prepares before a far transfer. Each cycle it receives one already-decoded instruction class, the current accumulator value and the instruction's signed immediate byte. From these it works out where the next fetch goes. When the instruction is a call, it also works out the value the accumulator owner must capture at the same clock edge.

Calls leave their way back in the accumulator, so no separate return instruction or return stack is needed. A near call writes a negated offset, and a plain relative jump by that value lands just past the call. A far call exchanges the fetch segment with the code-segment register and writes the address after the call, so a plain absolute jump returns to the caller. Fetching instructions, the accumulator itself and memory all sit outside the block. The fetch address is the pair (fetch segment, PC).

Top module: `flow_unit`

## Requirements
- R1: A synchronous active-high reset sets the PC, the fetch segment and the code-segment register to zero.
- R2: Op code 0 (single-byte step) advances the PC by 1 and op code 1 (two-byte step) advances it by 2. Both leave the segments unchanged and do not request an accumulator write.
- R3: Op code 2 (far jump) loads the PC with the accumulator and the fetch segment with the code-segment register. The code-segment register is left unchanged and there is no accumulator write.
- R4: Op code 3 (far call) loads the PC with the accumulator and the fetch segment with the code-segment register, and loads the code-segment register with the old fetch segment. In the same cycle it requests an accumulator write of PC+1, which wraps modulo 256.
- R5: Op code 4 (near jump) sets the PC to the PC plus the accumulator read as signed, modulo 256. Segments are unchanged and there is no accumulator write.
- R6: Op code 5 (near call) moves the PC like R5 and requests an accumulator write of 1 minus the accumulator (mod 256). A following near jump by that value reaches the call address plus 1.
- R7: Op code 6 (immediate jump) sets the PC to the PC plus the signed immediate, modulo 256, with no accumulator write.
- R8: Op code 7 (immediate call) moves the PC like R7 and requests an accumulator write of 2 minus the immediate (mod 256). A following near jump by that value reaches the call address plus 2.
- R9: Op code 8 (branch on zero) adds the signed immediate to the PC when the accumulator is zero and otherwise advances the PC by 2. It never writes the accumulator.
- R10: Op code 9 (segment load) copies the accumulator into the code-segment register and advances the PC by 1. The fetch segment is unchanged and there is no accumulator write.
- R11: Op codes 10 to 15 behave exactly like op code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Decoded flow class of the instruction at the current PC |
| acc_i | input | 8 | Current accumulator value |
| imm_i | input | 8 | Signed immediate byte of the instruction |
| pc_o | output | 8 | Program counter (address of the current instruction) |
| fseg_o | output | 8 | Segment instructions are fetched from |
| cseg_o | output | 8 | Code-segment register |
| acc_we_o | output | 1 | Request to write the accumulator at the coming edge |
| acc_wdata_o | output | 8 | Value to write into the accumulator |

## Verification
The hardest case to reach is a far call issued from PC 0xFF in a non-zero segment. The return address must wrap to 0x00 while the two segment registers swap. A later far jump must then bring back both the old segment and the wrapped address. The stimulus gets there by first loading a segment, then far-jumping to address 0xFF, then far-calling and returning. Near and immediate calls are each followed by a near jump that uses the written-back value, so the return points are checked as they are used. Branch-on-zero is driven with a zero and a non-zero accumulator back to back.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_STEP1  = 4'd0,
        OP_STEP2  = 4'd1,
        OP_JFAR   = 4'd2,
        OP_CFAR   = 4'd3,
        OP_JNEAR  = 4'd4,
        OP_CNEAR  = 4'd5,
        OP_JIMM   = 4'd6,
        OP_CIMM   = 4'd7,
        OP_BZERO  = 4'd8,
        OP_SETSEG = 4'd9
    } flow_op_e;

    // Control flags steering the target and link datapaths
    typedef struct packed {
        logic absolute;   // target comes from the accumulator, segment swap
        logic relative;   // target is pc + offset
        logic use_imm;    // offset source is the immediate byte
        logic cond_zero;  // relative move only when accumulator is zero
        logic is_call;    // accumulator receives a return value
        logic set_seg;    // code-segment register loads accumulator
        logic two_byte;   // instruction length is 2
    } flow_dec_t;

    function automatic flow_dec_t decode_op(input logic [OP_W-1:0] code);
        flow_dec_t d;
        d = '0;
        case (code)
            OP_STEP2:  d.two_byte = 1'b1;
            OP_JFAR:   d.absolute = 1'b1;
            OP_CFAR: begin
                d.absolute = 1'b1;
                d.is_call  = 1'b1;
            end
            OP_JNEAR:  d.relative = 1'b1;
            OP_CNEAR: begin
                d.relative = 1'b1;
                d.is_call  = 1'b1;
            end
            OP_JIMM: begin
                d.relative = 1'b1;
                d.use_imm  = 1'b1;
                d.two_byte = 1'b1;
            end
            OP_CIMM: begin
                d.relative = 1'b1;
                d.use_imm  = 1'b1;
                d.two_byte = 1'b1;
                d.is_call  = 1'b1;
            end
            OP_BZERO: begin
                d.relative  = 1'b1;
                d.use_imm   = 1'b1;
                d.cond_zero = 1'b1;
                d.two_byte  = 1'b1;
            end
            OP_SETSEG: d.set_seg = 1'b1;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output flow_dec_t       dec_o
);
    always_comb begin
        dec_o = decode_op(op_i);
    end
endmodule

// File: rtl/flow_target.sv
module flow_target
    import flow_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  flow_dec_t         dec_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   acc_i,
    input  logic [PC_W-1:0]   imm_i,
    output logic [PC_W-1:0]   next_pc_o
);
    localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
    localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

    logic [PC_W-1:0] offset;
    logic [PC_W-1:0] step;
    logic [PC_W-1:0] rel_target;
    logic [PC_W-1:0] seq_target;
    logic            acc_zero;
    logic            rel_take;

    always_comb begin
        offset     = dec_i.use_imm  ? imm_i    : acc_i;
        step       = dec_i.two_byte ? STEP_TWO : STEP_ONE;
        rel_target = pc_i + offset;
        seq_target = pc_i + step;
        acc_zero   = (acc_i == '0);
        rel_take   = dec_i.relative & (~dec_i.cond_zero | acc_zero);
        if (dec_i.absolute) begin
            next_pc_o = acc_i;
        end else if (rel_take) begin
            next_pc_o = rel_target;
        end else begin
            next_pc_o = seq_target;
        end
    end
endmodule

// File: rtl/flow_link.sv
module flow_link
    import flow_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int SEG_W = 8
) (
    input  flow_dec_t          dec_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [PC_W-1:0]    acc_i,
    input  logic [PC_W-1:0]    imm_i,
    input  logic [SEG_W-1:0]   fseg_i,
    input  logic [SEG_W-1:0]   cseg_i,
    output logic               acc_we_o,
    output logic [PC_W-1:0]    acc_wdata_o,
    output logic [SEG_W-1:0]   fseg_next_o,
    output logic [SEG_W-1:0]   cseg_next_o
);
    localparam logic [PC_W-1:0] LEN_ONE = PC_W'(1);
    localparam logic [PC_W-1:0] LEN_TWO = PC_W'(2);

    logic [SEG_W-1:0] seg_from_acc;
    logic [PC_W-1:0]  offset;
    logic [PC_W-1:0]  len;

    // Fit the accumulator into the segment width
    generate
        if (SEG_W == PC_W) begin : g_seg_same
            assign seg_from_acc = acc_i;
        end else if (SEG_W > PC_W) begin : g_seg_wide
            assign seg_from_acc = {{(SEG_W-PC_W){1'b0}}, acc_i};
        end else begin : g_seg_narrow
            assign seg_from_acc = acc_i[SEG_W-1:0];
        end
    endgenerate

    always_comb begin
        offset   = dec_i.use_imm  ? imm_i   : acc_i;
        len      = dec_i.two_byte ? LEN_TWO : LEN_ONE;
        acc_we_o = dec_i.is_call;
        // Far call returns by address, near call by negated offset
        if (dec_i.absolute) begin
            acc_wdata_o = pc_i + len;
        end else begin
            acc_wdata_o = len - offset;
        end

        fseg_next_o = dec_i.absolute ? cseg_i : fseg_i;

        if (dec_i.set_seg) begin
            cseg_next_o = seg_from_acc;
        end else if (dec_i.absolute && dec_i.is_call) begin
            cseg_next_o = fseg_i;
        end else begin
            cseg_next_o = cseg_i;
        end
    end
endmodule

// File: rtl/flow_unit.sv
module flow_unit
    import flow_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int SEG_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    op_i,
    input  logic [PC_W-1:0]    acc_i,
    input  logic [PC_W-1:0]    imm_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [SEG_W-1:0]   fseg_o,
    output logic [SEG_W-1:0]   cseg_o,
    output logic               acc_we_o,
    output logic [PC_W-1:0]    acc_wdata_o
);
    flow_dec_t        dec;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic [SEG_W-1:0] fseg_q, fseg_d;
    logic [SEG_W-1:0] cseg_q, cseg_d;

    flow_decode u_decode (
        .op_i  (op_i),
        .dec_o (dec)
    );

    flow_target #(.PC_W(PC_W)) u_target (
        .dec_i     (dec),
        .pc_i      (pc_q),
        .acc_i     (acc_i),
        .imm_i     (imm_i),
        .next_pc_o (pc_d)
    );

    flow_link #(.PC_W(PC_W), .SEG_W(SEG_W)) u_link (
        .dec_i       (dec),
        .pc_i        (pc_q),
        .acc_i       (acc_i),
        .imm_i       (imm_i),
        .fseg_i      (fseg_q),
        .cseg_i      (cseg_q),
        .acc_we_o    (acc_we_o),
        .acc_wdata_o (acc_wdata_o),
        .fseg_next_o (fseg_d),
        .cseg_next_o (cseg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            fseg_q <= '0;
            cseg_q <= '0;
        end else begin
            pc_q   <= pc_d;
            fseg_q <= fseg_d;
            cseg_q <= cseg_d;
        end
    end

    assign pc_o   = pc_q;
    assign fseg_o = fseg_q;
    assign cseg_o = cseg_q;
endmodule

// File: rtl/flow_unit_chk.sv
module flow_unit_chk
    import flow_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int SEG_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [OP_W-1:0]    op_i,
    input logic [PC_W-1:0]    acc_i,
    input logic [PC_W-1:0]    imm_i,
    input logic [PC_W-1:0]    pc_o,
    input logic [SEG_W-1:0]   fseg_o,
    input logic [SEG_W-1:0]   cseg_o,
    input logic               acc_we_o,
    input logic [PC_W-1:0]    acc_wdata_o
);
    logic was_rst;
    always_ff @(posedge clk) was_rst <= rst;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        was_rst |-> (pc_o == '0 && fseg_o == '0 && cseg_o == '0)); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_STEP1) |=> (pc_o == PC_W'($past(pc_o) + 1'b1))); // R2

    AST_FAR_JUMP: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_JFAR) |=> (pc_o == $past(acc_i) && fseg_o == $past(cseg_o)
                               && $stable(cseg_o))); // R3

    AST_FAR_CALL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CFAR) |=> (cseg_o == $past(fseg_o) && fseg_o == $past(cseg_o))); // R4

    AST_FAR_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_CFAR) |-> (acc_we_o && acc_wdata_o == PC_W'(pc_o + 1'b1))); // R4

    AST_IMM_JUMP: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_JIMM) |=> (pc_o == PC_W'($past(pc_o) + $past(imm_i)))); // R7

    AST_BZERO_FALL: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BZERO && acc_i != '0) |=> (pc_o == PC_W'($past(pc_o) + 2'd2))); // R9

    AST_WRITE_ONLY_CALLS: assert property (@(posedge clk) disable iff (rst)
        acc_we_o |-> (op_i == OP_CFAR || op_i == OP_CNEAR || op_i == OP_CIMM)); // R2

    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SETSEG) |=> ($stable(fseg_o) && cseg_o == SEG_W'($past(acc_i)))); // R10
endmodule

bind flow_unit flow_unit_chk #(.PC_W(PC_W), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/flow_unit_bench.sv
`timescale 1ns/1ps
module flow_unit_bench;
    import flow_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] op_i;
    logic [7:0] acc_i;
    logic [7:0] imm_i;
    logic [7:0] pc_o, fseg_o, cseg_o, acc_wdata_o;
    logic       acc_we_o;

    always #2 clk = ~clk;

    flow_unit u_flow_unit (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op_i),
        .acc_i       (acc_i),
        .imm_i       (imm_i),
        .pc_o        (pc_o),
        .fseg_o      (fseg_o),
        .cseg_o      (cseg_o),
        .acc_we_o    (acc_we_o),
        .acc_wdata_o (acc_wdata_o)
    );

    typedef struct {
        logic [7:0] pc;
        logic [7:0] fseg;
        logic [7:0] cseg;
        logic       we;
        logic [7:0] wd;
        string      st_tag;
        string      wr_tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    errors = 0;
    logic [7:0] m_pc = 8'h00, m_fseg = 8'h00, m_cseg = 8'h00;
    string last_tag = "R1";
    logic [7:0] last_wd = 8'h00;
    logic [7:0] ret_pc  = 8'h00;

    // Driver: applies one instruction and pushes what the outputs must show
    task automatic issue(input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] i, input string tag);
        exp_t e;
        logic [7:0] nxt_pc, nxt_f, nxt_c, wd;
        logic       we;
        @(negedge clk);
        rst = 1'b0; op_i = op; acc_i = a; imm_i = i;
        nxt_pc = m_pc + 8'd1; nxt_f = m_fseg; nxt_c = m_cseg; we = 1'b0; wd = 8'h00;
        case (op)
            4'd1: nxt_pc = m_pc + 8'd2;
            4'd2: begin nxt_pc = a; nxt_f = m_cseg; end
            4'd3: begin nxt_pc = a; nxt_f = m_cseg; nxt_c = m_fseg;
                        we = 1'b1; wd = m_pc + 8'd1; end
            4'd4: nxt_pc = m_pc + a;
            4'd5: begin nxt_pc = m_pc + a; we = 1'b1; wd = 8'd1 - a; end
            4'd6: nxt_pc = m_pc + i;
            4'd7: begin nxt_pc = m_pc + i; we = 1'b1; wd = 8'd2 - i; end
            4'd8: nxt_pc = (a == 8'h00) ? m_pc + i : m_pc + 8'd2;
            4'd9: nxt_c = a;
            default: ;
        endcase
        e.pc = m_pc; e.fseg = m_fseg; e.cseg = m_cseg;
        e.we = we; e.wd = wd; e.st_tag = last_tag; e.wr_tag = tag;
        sb.push_back(e);
        ret_pc = m_pc;
        m_pc = nxt_pc; m_fseg = nxt_f; m_cseg = nxt_c;
        last_tag = tag; last_wd = wd;
    endtask

    // Monitor: compares outputs after inputs of the cycle have settled
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pc_o !== e.pc || fseg_o !== e.fseg || cseg_o !== e.cseg) begin
                    errors++;
                    $display("FAIL %s state: actual pc=%h fseg=%h cseg=%h expected pc=%h fseg=%h cseg=%h",
                             e.st_tag, pc_o, fseg_o, cseg_o, e.pc, e.fseg, e.cseg);
                end
                checks++;
                if (acc_we_o !== e.we || (e.we && acc_wdata_o !== e.wd)) begin
                    errors++;
                    $display("FAIL %s writeback: actual we=%b data=%h expected we=%b data=%h",
                             e.wr_tag, acc_we_o, acc_wdata_o, e.we, e.wd);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual run still going, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = 4'd1; acc_i = 8'h37; imm_i = 8'h11;
        repeat (4) @(negedge clk);
        issue(4'd0, 8'h00, 8'h00, "R1");      // first item checks reset state
        issue(4'd1, 8'h22, 8'h05, "R2");
        issue(4'd0, 8'h00, 8'h00, "R2");
        issue(4'd12, 8'h44, 8'h66, "R11");
        issue(4'd15, 8'h00, 8'h00, "R11");
        issue(4'd9, 8'h5A, 8'h00, "R10");
        issue(4'd4, 8'h10, 8'h00, "R5");
        issue(4'd4, 8'hF0, 8'h00, "R5");      // backward move
        issue(4'd5, 8'h20, 8'h00, "R6");
        issue(4'd4, last_wd, 8'h00, "R6");    // return lands after the call
        issue(4'd7, 8'h00, 8'h30, "R8");
        issue(4'd4, last_wd, 8'h00, "R8");    // return lands two past the call
        issue(4'd8, 8'h00, 8'hF8, "R9");      // taken
        issue(4'd8, 8'h05, 8'hF8, "R9");      // falls through
        issue(4'd6, 8'h00, 8'h7F, "R7");
        issue(4'd6, 8'h00, 8'h7F, "R7");      // wraps past 0xFF
        issue(4'd3, 8'h40, 8'h00, "R4");      // far call into segment 0x5A
        issue(4'd2, last_wd, 8'h00, "R3");    // far return to segment 0
        issue(4'd9, 8'h33, 8'h00, "R10");
        issue(4'd2, 8'hFF, 8'h00, "R3");      // enter segment 0x33 at 0xFF
        issue(4'd3, 8'h10, 8'h00, "R4");      // return address wraps to 0x00
        issue(4'd2, last_wd, 8'h00, "R3");    // back to segment 0x33, address 0x00
        issue(4'd5, 8'h00, 8'h00, "R6");      // zero offset near call
        issue(4'd0, 8'h00, 8'h00, "R2");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule